// File: doc/BRIEF.md
# Bit-Serial Adder with Run Control

This block adds two unsigned operands of `WIDTH` bits by handling one bit position per clock, starting at the least significant bit. A synchronous reset loads both operands into right-shifting registers, clears the result register and the held carry, and starts a run. On each run cycle the low bits of both operand registers go into a one-bit carry machine. That machine forms the sum bit, and the sum bit is pushed into the top of the result register. A down-counter sets the number of run cycles to exactly `WIDTH`, and all shifting halts once the counter reaches zero.

A parameter selects between two forms of the carry machine. The combinational-output form has two states and passes each sum bit to the result register in the same cycle. The registered-output form has four states, which hold the carry together with the last sum bit. Each sum bit then reaches the result register one clock later, so the result register is enabled for one extra cycle. The `active` output is high for as long as the result register is still changing. The sum wraps modulo 2^WIDTH, and no carry-out is reported.

Top module: `serial_adder_top`

## Requirements
- R1: A clock edge with `rst` high loads `op_a` and `op_b`, clears `sum` to zero and clears the carry. In the cycle after `rst` falls, `sum` is zero and `active` is 1.
- R2: With `REG_SUM_BIT=0`, `sum` equals (`op_a` + `op_b`) mod 2^WIDTH after exactly WIDTH clock edges without reset following the loading edge.
- R3: The result fills from the top. With `REG_SUM_BIT=0`, after j run edges (j ≤ WIDTH), bits [WIDTH-1:WIDTH-j] of `sum` hold bits [j-1:0] of the true sum and all lower bits are zero.
- R4: The held carry goes from 0 to 1 only when both operand bits are 1. It goes from 1 to 0 only when both operand bits are 0. This includes carry chains that run the full width, such as 0xFF+0x01.
- R5: With `REG_SUM_BIT=0`, `active` is high for exactly WIDTH cycles after the loading edge and then stays low until the next reset.
- R6: While `active` is low and `rst` is low, `sum` does not change.
- R7: With `REG_SUM_BIT=1`, each sum bit enters `sum` one clock after its operand bits are used. `active` lasts WIDTH+1 cycles, after j enable edges the top j-1 bits hold the low j-1 sum bits, and the final value equals that of R2.
- R8: Holding `rst` high for several cycles reloads the block on every edge and does no shifting. Asserting `rst` during a run abandons that run and starts a new one with the current operands.
- R9: Changes on `op_a` and `op_b` while `rst` is low have no effect on `sum` or `active`.
- R10: The carry out of the top bit position is dropped. For example, 0xFF+0x01 gives 0x00 and 0xFF+0xFF gives 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loads operands and starts a run |
| op_a | input | WIDTH | First operand, sampled on reset edges |
| op_b | input | WIDTH | Second operand, sampled on reset edges |
| sum | output | WIDTH | Result register, filled from the top |
| active | output | 1 | High while the result register is still shifting |

## Verification
The assertions check on every cycle that reset leaves an empty result with a live run, that the carry changes only on the two allowed operand bit pairs, that the run ends one edge after the counter's last step and does not restart without reset, and that the result is frozen whenever the block is idle. Only the bench scenarios can show the arithmetic itself. It compares two instances, one of each output form, against an integer model of the partial sum after every edge. The scenarios cover full-width carry chains, wrap-around, operands that change mid-run, reset held high for several cycles, and a restart in the middle of a run.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    CY_CLEAR = 1'b0,
    CY_SET   = 1'b1
  } carry_e;

  // registered-output form: {carry, last sum bit}
  typedef enum logic [1:0] {
    MS_C0_S0 = 2'b00,
    MS_C0_S1 = 2'b01,
    MS_C1_S0 = 2'b10,
    MS_C1_S1 = 2'b11
  } moore_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic             shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  generate
    if (WIDTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (load)       q <= par_in;
        else if (shift) q <= ser_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (load)       q <= par_in;
        else if (shift) q <= {ser_in, q[WIDTH-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/sa_run_counter.sv
module sa_run_counter #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          run
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIDTH);

  always_ff @(posedge clk) begin
    if (start) begin
      cnt <= LOAD_VAL;
      run <= 1'b1;
    end else if (run) begin
      cnt <= cnt - 1'b1;
      run <= (cnt != CW'(1));
    end
  end
endmodule

// File: rtl/sa_carry_fsm.sv
module sa_carry_fsm
  import sa_pkg::*;
#(
  parameter bit REG_SUM_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic carry,
  output logic sum_bit
);
  generate
    if (REG_SUM_BIT) begin : g_moore
      moore_e st, st_nx;
      always_comb begin
        st_nx = st;
        if (step)
          st_nx = moore_e'({maj3(a_bit, b_bit, st[1]), a_bit ^ b_bit ^ st[1]});
      end
      always_ff @(posedge clk) begin
        if (rst) st <= MS_C0_S0;
        else     st <= st_nx;
      end
      assign carry   = st[1];
      assign sum_bit = st[0];
    end else begin : g_mealy
      carry_e cy, cy_nx;
      always_comb begin
        cy_nx = cy;
        if (step) begin
          unique case (cy)
            CY_CLEAR: if (a_bit & b_bit)    cy_nx = CY_SET;
            CY_SET:   if (!(a_bit | b_bit)) cy_nx = CY_CLEAR;
            default:  cy_nx = CY_CLEAR;
          endcase
        end
      end
      always_ff @(posedge clk) begin
        if (rst) cy <= CY_CLEAR;
        else     cy <= cy_nx;
      end
      assign carry   = cy;
      assign sum_bit = a_bit ^ b_bit ^ cy;
    end
  endgenerate
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top #(
  parameter int WIDTH       = 8,
  parameter bit REG_SUM_BIT = 1'b0,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             active
);
  logic [WIDTH-1:0] a_q, b_q;
  logic [CW-1:0]    cnt;
  logic             run, carry, sum_bit, sum_en;
  logic             a_lsb, b_lsb;

  assign a_lsb = a_q[0];
  assign b_lsb = b_q[0];

  sa_shift_reg #(.WIDTH(WIDTH)) u_opa (
    .clk(clk), .load(rst), .shift(run), .ser_in(1'b0), .par_in(op_a), .q(a_q));
  sa_shift_reg #(.WIDTH(WIDTH)) u_opb (
    .clk(clk), .load(rst), .shift(run), .ser_in(1'b0), .par_in(op_b), .q(b_q));

  sa_run_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .start(rst), .cnt(cnt), .run(run));

  sa_carry_fsm #(.REG_SUM_BIT(REG_SUM_BIT)) u_fsm (
    .clk(clk), .rst(rst), .step(run), .a_bit(a_lsb), .b_bit(b_lsb),
    .carry(carry), .sum_bit(sum_bit));

  generate
    if (REG_SUM_BIT) begin : g_tail
      logic tail;
      always_ff @(posedge clk) begin
        if (rst) tail <= 1'b0;
        else     tail <= run && (cnt == CW'(1));
      end
      assign sum_en = run | tail;
    end else begin : g_notail
      assign sum_en = run;
    end
  endgenerate

  sa_shift_reg #(.WIDTH(WIDTH)) u_sum (
    .clk(clk), .load(rst), .shift(sum_en), .ser_in(sum_bit),
    .par_in({WIDTH{1'b0}}), .q(sum));

  assign active = sum_en;
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic [WIDTH-1:0] sum,
  input logic             run,
  input logic [CW-1:0]    cnt,
  input logic             carry,
  input logic             a_lsb,
  input logic             b_lsb
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum == '0) && active && !carry);

  assert_carry_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !carry && !(a_lsb && b_lsb)) |=> !carry);

  assert_carry_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (run && carry && (a_lsb || b_lsb)) |=> carry);

  assert_run_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CW'(1)) |=> !run);

  assert_run_stays_off_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !run);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(sum));
endmodule

bind serial_adder_top sa_checker #(.WIDTH(WIDTH)) u_sa_checker (
  .clk(clk), .rst(rst), .active(active), .sum(sum), .run(run), .cnt(cnt),
  .carry(carry), .a_lsb(a_lsb), .b_lsb(b_lsb));

// File: tb/serial_adder_top_bench.sv
module serial_adder_top_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum_c, sum_r;
  logic         act_c, act_r;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_adder_top #(.WIDTH(W), .REG_SUM_BIT(1'b0)) u_serial_adder_top (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum(sum_c), .active(act_c));
  serial_adder_top #(.WIDTH(W), .REG_SUM_BIT(1'b1)) u_serial_adder_top_reg (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum(sum_r), .active(act_r));

  // behavioural model: true sum and edge count since the last load
  logic [W-1:0] m_full;
  int           m_steps;
  bit           m_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_full  = op_a + op_b;
      m_steps = 0;
      m_valid = 1;
    end else if (m_valid && m_steps < W + 1) begin
      m_steps = m_steps + 1;
    end
  end

  function automatic logic [W-1:0] top_bits(input logic [W-1:0] v, input int n);
    if (n <= 0) return '0;
    return v << (W - n);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      int mc;
      int mr;
      mc = (m_steps < W) ? m_steps : W;
      mr = (m_steps < 1) ? 0 : ((m_steps - 1 < W) ? m_steps - 1 : W);
      check("R3 partial sum", sum_c, top_bits(m_full, mc));
      check("R5 active", {{(W-1){1'b0}}, act_c}, {{(W-1){1'b0}}, (m_steps < W)});
      check("R7 partial sum reg", sum_r, top_bits(m_full, mr));
      check("R7 active reg", {{(W-1){1'b0}}, act_r}, {{(W-1){1'b0}}, (m_steps < W + 1)});
    end
  end

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b, input int hold);
    @(negedge clk);
    op_a = a; op_b = b; rst = 1'b1;
    repeat (hold) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic full_run(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp;
    exp = a + b;
    load(a, b, 1);
    // now one cycle after the loading edge
    check("R1 sum cleared after load", sum_c, '0);
    check("R1 active after load", {{(W-1){1'b0}}, act_c}, {{(W-1){1'b0}}, 1'b1});
    repeat (W) @(negedge clk);
    check({tag, " R2 final sum"}, sum_c, exp);
    @(negedge clk);
    check({tag, " R7 final sum reg"}, sum_r, exp);
    repeat (3) @(negedge clk);
    check("R6 sum held when idle", sum_c, exp);
    check("R6 sum reg held when idle", sum_r, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    full_run("basic", 8'h37, 8'h21);
    full_run("zeros", 8'h00, 8'h00);
    full_run("R4 R10 carry chain", 8'hFF, 8'h01);
    full_run("R4 alternating", 8'h55, 8'hAA);
    full_run("R4 R10 all ones", 8'hFF, 8'hFF);
    full_run("R10 top carry", 8'h80, 8'h80);
    full_run("R4 carry kill", 8'h0F, 8'h71);

    // R9: operands change mid-run
    load(8'h5A, 8'h33, 1);
    repeat (3) @(negedge clk);
    op_a = 8'hFF; op_b = 8'hFF;
    repeat (W) @(negedge clk);
    check("R9 mid-run operand change", sum_c, 8'h8D);
    check("R9 mid-run operand change reg", sum_r, 8'h8D);

    // R8: reset held several cycles
    load(8'h12, 8'h34, 4);
    check("R8 long reset sum", sum_c, '0);
    repeat (W + 1) @(negedge clk);
    check("R8 long reset final", sum_c, 8'h46);
    check("R8 long reset final reg", sum_r, 8'h46);

    // R8: restart in the middle of a run
    load(8'hC3, 8'h3C, 1);
    repeat (4) @(negedge clk);
    load(8'h19, 8'h27, 1);
    check("R8 restart clears sum", sum_c, '0);
    repeat (W + 1) @(negedge clk);
    check("R8 restart final", sum_c, 8'h40);
    check("R8 restart final reg", sum_r, 8'h40);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule